// File: doc/BRIEF.md
# SPI Flash Status and Write-Protect Controller

This block keeps the eight-bit status byte of a small serial flash device and enforces the rules that decide whether a memory-modify request may start. The SPI front end decodes opcodes and presents one-cycle strobes: set the write-enable latch, clear it, write the status byte (with a data byte), or start a program or erase at a byte address. The block answers each request with a one-cycle accept or reject pulse. It also runs a parameterised down-counter that stands in for the array's program and erase times.

Protection has two parts. A three-bit level field chooses the size of a protected window, and a direction bit says whether that window sits at the top or the bottom of the array. A lock bit and the active-low write-protect pin together freeze the protection fields. While an operation is in flight, the controller ignores every command. Reading the status byte is the only thing that still works, because the byte is always visible on its output.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset every status bit is 0, busy is low, and neither response pulse is raised.
- R2: The status byte is packed as bit0 busy, bit1 write-enable latch, bits 4:2 protection level, bit5 direction, bit6 always 0, bit7 lock. A status write can never change bits 0, 1 or 6.
- R3: While idle, a set-enable strobe sets the latch to 1 and a clear-enable strobe sets it to 0.
- R4: While idle with the latch at 1, a status write loads bits 7:2 (subject to R5) and clears the latch. While idle with the latch at 0, a status write changes nothing.
- R5: When the lock bit is 1 or wp_n is 0, a status write leaves the level and direction bits unchanged. When wp_n is 0, the lock bit is unchanged as well. With wp_n at 1, the lock bit stays writable.
- R6: A request made while idle with the latch at 0 is rejected and leaves the status byte unchanged.
- R7: A level L of 0 protects nothing. A level L of 1 or more protects a window of 64 KB × 2^(L−1), capped at the whole array. That window is the top of the array when the direction bit is 0 and the bottom when it is 1. A sector, block or page request whose address falls inside the window is rejected and clears the latch. A chip erase (req_op 3) is rejected whenever the level is not 0.
- R8: An accepted request holds busy high for a number of cycles set by req_op: 0 gives page program (PP_CYC), 1 sector erase (SE_CYC), 2 block erase (BE_CYC), 3 chip erase (CE_CYC). Busy and the latch fall on the same cycle.
- R9: While busy, every strobe is ignored and no response pulse is produced.
- R10: req_accept and req_reject each pulse for one cycle, in the cycle after the request, and never together. The accept pulse and busy rise in the same cycle.
- R11: When strobes coincide, a request wins over a status write, a status write over clear-enable, and clear-enable over set-enable. A strobe that loses does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrdi | input | 1 | Clear write-enable latch strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| req_valid | input | 1 | Program or erase request strobe |
| req_op | input | 2 | 0 page program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte address |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte |
| busy | output | 1 | Operation in progress |
| req_accept | output | 1 | Request accepted pulse |
| req_reject | output | 1 | Request rejected pulse |

## Verification
On every cycle, the embedded properties check these behaviours:
- the latch stays set for the whole busy window, and busy falls right after the completion strobe;
- the counter only starts while idle;
- frozen fields hold across a status write made under the lock or under wp_n;
- a zero protection level never reports a hit;
- the two response pulses never coincide.

Only the bench scenarios can show the rest, because those checks need the cycle-level reference model to supply expected values:
- the exact busy length for each operation;
- where the protected window falls for each level and direction, including the 64 KB edges and the cap at the whole array;
- the priority order among coinciding strobes.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    OP_PAGE = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef struct packed {
    logic       lock;
    logic       rsv;
    logic       dir;
    logic [2:0] lvl;
    logic       wel;
    logic       busy;
  } stat_t;

  // Window check: lvl 0 => none, else 2^(blk_w+lvl-1) bytes at top (dir=0) or bottom (dir=1).
  function automatic logic prot_hit(input logic [2:0] lvl, input logic dir,
                                    input logic [31:0] addr,
                                    input int unsigned aw, input int unsigned bw);
    logic [63:0] span, whole, a;
    int unsigned sh;
    if (lvl == 3'd0) return 1'b0;
    sh    = bw + int'(lvl) - 1;
    whole = 64'd1 << aw;
    span  = 64'd1 << sh;
    if (span >= whole) return 1'b1;
    a = {32'd0, addr};
    if (dir) return a < span;
    return a >= (whole - span);
  endfunction

endpackage

// File: rtl/fsr_prot_check.sv
module fsr_prot_check
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        lvl,
  input  logic              dir,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int unsigned PAD_W = 32 - ADDR_W;

  logic [31:0] addr_ext;
  logic        window_hit;

  assign addr_ext   = {{PAD_W{1'b0}}, addr};
  assign window_hit = prot_hit(lvl, dir, addr_ext, ADDR_W, BLK_W);

  always_comb begin
    if (op_e'(op) == OP_CHIP) hit = (lvl != 3'd0);
    else                      hit = window_hit;
  end

  p_lvl0_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 3'd0) |-> !hit);

endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer
  import fsr_pkg::*;
#(
  parameter int unsigned PP_CYC = 6,
  parameter int unsigned SE_CYC = 10,
  parameter int unsigned BE_CYC = 14,
  parameter int unsigned CE_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  output logic       busy,
  output logic       done
);

  localparam int unsigned MAX_A = (PP_CYC > SE_CYC) ? PP_CYC : SE_CYC;
  localparam int unsigned MAX_B = (BE_CYC > CE_CYC) ? BE_CYC : CE_CYC;
  localparam int unsigned MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_len;

  always_comb begin
    unique case (op_e'(op))
      OP_PAGE: load_len = CNT_W'(PP_CYC);
      OP_SECT: load_len = CNT_W'(SE_CYC);
      OP_BLK:  load_len = CNT_W'(BE_CYC);
      default: load_len = CNT_W'(CE_CYC);
    endcase
  end

  assign busy = (cnt_q != '0);
  assign done = busy && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= load_len;
    else if (busy)  cnt_q <= cnt_q - CNT_W'(1);
  end

  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_steps_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       sr_wr,
  input  stat_t      sr_data,
  output logic       lock,
  output logic       dir,
  output logic [2:0] lvl,
  output logic       wel
);

  logic frozen;
  assign frozen = lock || !wp_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock <= 1'b0;
      dir  <= 1'b0;
      lvl  <= 3'd0;
    end else if (sr_wr) begin
      if (!frozen) begin
        dir <= sr_data.dir;
        lvl <= sr_data.lvl;
      end
      if (wp_n) lock <= sr_data.lock;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wel <= 1'b0;
    else if (clr_wel) wel <= 1'b0;
    else if (set_wel) wel <= 1'b1;
  end

  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && frozen) |=> ($stable(lvl) && $stable(dir)));
  p_pin_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && !wp_n) |=> $stable(lock));
  p_no_set_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wel && clr_wel));

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned PP_CYC = 6,
  parameter int unsigned SE_CYC = 10,
  parameter int unsigned BE_CYC = 14,
  parameter int unsigned CE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              busy,
  output logic              req_accept,
  output logic              req_reject
);

  logic       idle;
  logic       take_req, take_wrsr, take_wrdi, take_wren;
  logic       req_ok, req_bad, prot_reject;
  logic       set_wel, clr_wel;
  logic       hit, done;
  logic       lock, dir, wel;
  logic [2:0] lvl;
  logic       acc_q, rej_q;
  stat_t      wr_view, cur;

  assign wr_view = stat_t'(wrsr_data);
  assign idle    = !busy;

  // Strobe arbitration: request > status write > clear-enable > set-enable.
  assign take_req  = idle && req_valid;
  assign take_wrsr = idle && !req_valid && cmd_wrsr && wel;
  assign take_wrdi = idle && !req_valid && !cmd_wrsr && cmd_wrdi;
  assign take_wren = idle && !req_valid && !cmd_wrsr && !cmd_wrdi && cmd_wren;

  assign req_ok      = take_req && wel && !hit;
  assign prot_reject = take_req && wel && hit;
  assign req_bad     = take_req && !req_ok;

  assign clr_wel = take_wrdi || take_wrsr || done || prot_reject;
  assign set_wel = take_wren;

  fsr_prot_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_prot (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl),
    .dir  (dir),
    .op   (req_op),
    .addr (req_addr),
    .hit  (hit)
  );

  fsr_busy_timer #(
    .PP_CYC(PP_CYC), .SE_CYC(SE_CYC), .BE_CYC(BE_CYC), .CE_CYC(CE_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(req_ok),
    .op   (req_op),
    .busy (busy),
    .done (done)
  );

  fsr_status_reg u_sr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wp_n   (wp_n),
    .set_wel(set_wel),
    .clr_wel(clr_wel),
    .sr_wr  (take_wrsr),
    .sr_data(wr_view),
    .lock   (lock),
    .dir    (dir),
    .lvl    (lvl),
    .wel    (wel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= req_ok;
      rej_q <= req_bad;
    end
  end

  always_comb begin
    cur.lock = lock;
    cur.rsv  = 1'b0;
    cur.dir  = dir;
    cur.lvl  = lvl;
    cur.wel  = wel;
    cur.busy = busy;
  end

  assign status     = cur;
  assign req_accept = acc_q;
  assign req_reject = rej_q;

  p_wel_during_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> busy);
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_accept && req_reject));
  p_busy_ignores_wrsr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wrsr) |=> $stable(status[7:2]));
  p_nowel_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idle && !wel) |=> (req_reject && $stable(status)));

endmodule

// File: tb/sim_flash_sr_guard.sv
module sim_flash_sr_guard;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int PPC = 6, SEC = 10, BEC = 14, CEC = 20;
  localparam int ARRAY = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, req_valid = 0, wp_n = 1;
  logic [7:0]    wrsr_data = 0;
  logic [1:0]    req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [7:0]    status;
  logic          busy, req_accept, req_reject;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_left = 0;
  bit m_wel = 0, m_lock = 0, m_dir = 0, m_acc = 0, m_rej = 0;
  int m_lvl = 0;

  flash_sr_guard #(.ADDR_W(AW), .BLK_W(16), .PP_CYC(PPC), .SE_CYC(SEC),
                   .BE_CYC(BEC), .CE_CYC(CEC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .wp_n(wp_n), .status(status),
    .busy(busy), .req_accept(req_accept), .req_reject(req_reject));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_hit(int lvl, bit dir, int op, int addr);
    longint bytes;
    if (op == 3) return lvl != 0;
    if (lvl == 0) return 0;
    bytes = 65536;
    for (int k = 1; k < lvl; k++) bytes = bytes * 2;
    if (bytes > ARRAY) bytes = ARRAY;
    if (dir) return addr < bytes;
    return addr >= ARRAY - bytes;
  endfunction

  function automatic int op_cycles(int op);
    case (op)
      0: return PPC;
      1: return SEC;
      2: return BEC;
      default: return CEC;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_wel = 0; m_lock = 0; m_dir = 0; m_lvl = 0; m_acc = 0; m_rej = 0;
    end else begin
      m_acc = 0; m_rej = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_wel = 0;
      end else if (req_valid) begin
        if (!m_wel) m_rej = 1;
        else if (model_hit(m_lvl, m_dir, int'(req_op), int'(req_addr))) begin
          m_rej = 1; m_wel = 0;
        end else begin
          m_acc = 1; m_left = op_cycles(int'(req_op));
        end
      end else if (cmd_wrsr) begin
        if (m_wel) begin
          if (!m_lock && wp_n) begin
            m_dir = wrsr_data[5];
            m_lvl = int'(wrsr_data[4:2]);
          end
          if (wp_n) m_lock = wrsr_data[7];
          m_wel = 0;
        end
      end else if (cmd_wrdi) m_wel = 0;
      else if (cmd_wren) m_wel = 1;
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_st;
    cycles++;
    if (rst_n) begin
      exp_st = {m_lock, 1'b0, m_dir, 3'(m_lvl), m_wel, (m_left > 0)};
      compared++;
      if (status !== exp_st || busy !== (m_left > 0) ||
          req_accept !== m_acc || req_reject !== m_rej) begin
        mismatched++;
        $display("FAIL %s t=%0t status=%h busy=%b acc=%b rej=%b expected status=%h busy=%b acc=%b rej=%b",
                 cur_req, $time, status, busy, req_accept, req_reject,
                 exp_st, (m_left > 0), m_acc, m_rej);
      end
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wren();
    cmd_wren = 1; @(negedge clk); cmd_wren = 0;
  endtask

  task automatic wrdi();
    cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
  endtask

  task automatic wrsr(logic [7:0] d);
    cmd_wrsr = 1; wrsr_data = d; @(negedge clk); cmd_wrsr = 0;
  endtask

  task automatic req(int op, int addr);
    req_valid = 1; req_op = 2'(op); req_addr = AW'(addr);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic set_prot(logic [7:0] d);
    wren(); wrsr(d); idle(1);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    idle(1);
  endtask

  initial begin
    cur_req = "R1";
    idle(3); rst_n = 1; idle(3);

    cur_req = "R3";
    wren(); idle(1); wrdi(); idle(1); wren(); idle(1);

    cur_req = "R6";
    wrdi(); req(1, 'h1000); idle(2); req(0, 'h0); idle(1);

    cur_req = "R2";
    wren(); wrsr(8'hFF); idle(2);          // bit6/1/0 of data must not land
    cur_req = "R4";
    wrsr(8'h00); idle(1);                  // latch is 0: ignored

    cur_req = "R5";
    wren(); wrsr(8'h00); idle(1);          // lock=1, wp_n=1: only lock clears
    wp_n = 0;
    wren(); wrsr(8'h9C); idle(1);          // pin low: nothing changes
    wp_n = 1; idle(1);
    wren(); wrsr(8'h00); idle(1);          // now unlocked: fields clear
    wren(); wrsr(8'h80); idle(1);          // lock with lvl 0
    wren(); wrsr(8'h14); idle(1);          // frozen lvl/dir, lock cleared
    set_prot(8'h00);

    cur_req = "R7";
    set_prot(8'h04);                       // 64 KB top
    wren(); req(1, 'h7F000); idle(1);      // inside: reject, latch cleared
    wren(); req(1, 'h6F000); idle(1); wait_done();   // just below: accept
    wren(); req(0, 'h70000); idle(1);      // first byte of window
    set_prot(8'h28);                       // dir=1, lvl 2: bottom 128 KB
    wren(); req(2, 'h10000); idle(1);
    wren(); req(0, 'h1FFFF); idle(1);
    wren(); req(1, 'h20000); idle(1); wait_done();
    wren(); req(3, 0); idle(1);            // chip erase blocked
    set_prot(8'h14);                       // lvl 5: whole array
    wren(); req(0, 'h00000); idle(1);
    wren(); req(0, 'h40000); idle(1);
    set_prot(8'h00);

    cur_req = "R8";
    for (int op = 0; op < 4; op++) begin
      wren(); req(op, 'h3000); wait_done();
    end

    cur_req = "R9";
    wren(); req(2, 'h50000); idle(1);
    wrdi(); wren(); wrsr(8'h1C); req(1, 'h0); idle(1);
    wait_done();

    cur_req = "R10";
    wren(); req(0, 'h100); idle(2); wait_done();

    cur_req = "R11";
    wren(); cmd_wren = 1; cmd_wrdi = 1; @(negedge clk); cmd_wren = 0; cmd_wrdi = 0; idle(1);
    wren(); cmd_wrsr = 1; wrsr_data = 8'h0C; cmd_wrdi = 1; @(negedge clk);
    cmd_wrsr = 0; cmd_wrdi = 0; idle(1);
    wren(); req_valid = 1; req_op = 2'd1; req_addr = AW'('h2000); cmd_wrsr = 1; wrsr_data = 8'h00;
    @(negedge clk); req_valid = 0; cmd_wrsr = 0;
    idle(1); wait_done();

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule